// File: doc/BRIEF.md
# Banked Register-File Address Mapper

This block turns a data-memory access request of a small processor core into the target it actually hits in a 512-location banked register space. The space is split into four banks of 128 locations. A direct access builds its address from a two-bit bank selector and a seven-bit field of the opcode. An indirect access builds it from a one-bit bank-pair selector and an eight-bit pointer register. Offset 00h of every bank is a virtual register: touching it redirects the access through the pointer.

The mapper resolves the virtual register and folds every mirrored location onto one canonical target. The top sixteen offsets of each bank share one block of common RAM. A small set of core special registers sits at the same offsets in all four banks, and two upper-bank special locations mirror the lower banks. Holes in the map are flagged so that the register file returns zero and drops writes. Each request yields, one clock later, exactly one of three results: a physical RAM index (0 to 223), a canonical special-register address, or a read-as-zero flag. A write strobe that is already gated for the holes comes with it.

Top module: `bankmap_top`

## Requirements
- R1: A direct access (isIndirect=0) whose opcode field is not 0 uses the effective address {bankSel, opField}; bankSel values 0, 1, 2 and 3 select banks 0 to 3, and the bank is bits 8:7 of the effective address.
- R2: An indirect access (isIndirect=1) uses the effective address {irpBit, ptrVal}, whatever bankSel and opField hold.
- R3: A direct access with opField = 00h is redirected: its effective address is {irpBit, ptrVal}.
- R4: When the effective address has offset (bits 6:0) equal to 00h, the access points at the virtual register through itself: readZero is set and no write strobe is given.
- R5: Offsets 70h to 7Fh of any bank hit common RAM at ramIdx = 208 + (offset - 70h), the same index for all four banks.
- R6: The other general-purpose RAM maps as follows: bank 0 offsets 20h to 6Fh go to ramIdx = offset - 20h; bank 1 offsets 20h to 6Fh go to 80 + offset - 20h; bank 2 offsets 20h to 4Fh go to 160 + offset - 20h. Bank 2 offsets 50h to 6Fh and bank 3 offsets 20h to 6Fh are unimplemented.
- R7: Offsets 02h, 03h, 04h, 0Ah and 0Bh are core special registers in every bank: sfrSel is set and sfrAddr is the 9-bit value {2'b00, offset}.
- R8: In banks 2 and 3, offsets 01h and 06h mirror banks 0 and 1: sfrAddr is {bank - 2, offset}. All other special-register offsets of banks 2 and 3 are unimplemented.
- R9: In banks 0 and 1, the special-register offsets (below 20h) that are neither core nor 00h give sfrSel with sfrAddr equal to the effective address when implemented, and readZero otherwise. Bank 0 implements 01h, 05h, 06h, 0Ch, 0Eh to 12h, 15h to 1Ah and 1Fh; bank 1 implements 01h, 05h, 06h, 0Ch, 0Eh, 12h, 18h to 1Dh and 1Fh.
- R10: Unimplemented locations give readZero; wrEn is high only for a write request that hits RAM or a special register, so a write to a hole changes nothing.
- R11: Results appear one clock after the request: rspValid follows reqValid with one cycle of delay, and exactly one of ramSel, sfrSel and readZero is high while rspValid is high. With no request, and during reset, all outputs are 0. ramIdx is 0 when ramSel is low, and sfrAddr is 0 when sfrSel is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | An access request is present this cycle |
| reqWrite | input | 1 | The request is a write |
| isIndirect | input | 1 | 1 = pointer-based access, 0 = direct access |
| bankSel | input | 2 | Bank selector for direct accesses |
| opField | input | 7 | Register field of the opcode |
| irpBit | input | 1 | Bank-pair selector for pointer-based accesses |
| ptrVal | input | 8 | Current pointer register value |
| rspValid | output | 1 | A result is present |
| ramSel | output | 1 | The result targets general-purpose RAM |
| ramIdx | output | 8 | Physical RAM index, 0 to 223 |
| sfrSel | output | 1 | The result targets a special register |
| sfrAddr | output | 9 | Canonical special-register address |
| readZero | output | 1 | Unimplemented or self-referencing: reads return 0 |
| wrEn | output | 1 | Gated write strobe for the selected target |

## Verification
Every decision in the mapper lands in one registered result, so a wrong classification shows one cycle after the request as the wrong one of the three select lines, and a wrong fold shows in the same cycle as a RAM index or special-register address that differs from the one computed from the map. A mirrored location that escapes folding would give two different indices for one physical byte, so the sweeps compare each of the 512 direct and 512 pointer-based addresses against the model. A hole that is not flagged shows at once as a raised wrEn on a write that should have been dropped.

// File: rtl/bankmap_pkg.sv
package bankmap_pkg;

  typedef enum logic [1:0] {
    RGN_B0     = 2'd0,
    RGN_B1     = 2'd1,
    RGN_B2     = 2'd2,
    RGN_COMMON = 2'd3
  } ramRgn_e;

  // Strobes from the classifier to the datapath.
  typedef struct packed {
    logic       hitRam;
    logic       hitSfr;
    logic       hitZero;
    ramRgn_e    rgn;
    logic [1:0] sfrBank;
  } mapStrobe_t;

endpackage

// File: rtl/bankmap_ctrl.sv
module bankmap_ctrl
  import bankmap_pkg::*;
#(
  parameter int          OFF_W       = 7,
  parameter int          BANK_W      = 2,
  parameter int          COMMON_SIZE = 16,
  parameter int          B2_GPR_TOP  = 'h50,
  parameter logic [31:0] CORE_MAP    = 32'h0000_0C1C,
  parameter logic [31:0] HIGH_MIRROR = 32'h0000_0042,
  parameter logic [31:0] B0_SFR_MAP  = 32'h87E7_DC7F,
  parameter logic [31:0] B1_SFR_MAP  = 32'hBF04_5C7F
) (
  input  logic [BANK_W+OFF_W-1:0] effAddr,
  output mapStrobe_t              strb
);
  localparam int SFR_SPAN  = 2 ** (OFF_W - 2);
  localparam int COMMON_LO = 2 ** OFF_W - COMMON_SIZE;

  logic [OFF_W-1:0]  off;
  logic [BANK_W-1:0] bank;
  logic [4:0]        sfrOff;

  assign off    = effAddr[OFF_W-1:0];
  assign bank   = effAddr[BANK_W+OFF_W-1:OFF_W];
  assign sfrOff = off[4:0];

  always_comb begin
    strb = '{hitRam: 1'b0, hitSfr: 1'b0, hitZero: 1'b1,
             rgn: RGN_B0, sfrBank: 2'd0};
    if (off == '0) begin
      strb.hitZero = 1'b1;              // pointer aimed at itself (R4)
    end else if (int'(off) >= COMMON_LO) begin
      strb.hitZero = 1'b0;
      strb.hitRam  = 1'b1;
      strb.rgn     = RGN_COMMON;        // shared by all banks (R5)
    end else if (int'(off) >= SFR_SPAN) begin
      unique case (bank)
        2'd0: begin strb.hitRam = 1'b1; strb.hitZero = 1'b0; strb.rgn = RGN_B0; end
        2'd1: begin strb.hitRam = 1'b1; strb.hitZero = 1'b0; strb.rgn = RGN_B1; end
        2'd2: if (int'(off) < B2_GPR_TOP) begin
                strb.hitRam = 1'b1; strb.hitZero = 1'b0; strb.rgn = RGN_B2;
              end
        default: ;                      // bank 3 has no private RAM (R6)
      endcase
    end else if (CORE_MAP[sfrOff]) begin
      strb.hitSfr  = 1'b1;              // core registers fold to bank 0 (R7)
      strb.hitZero = 1'b0;
      strb.sfrBank = 2'd0;
    end else if (bank[1]) begin
      if (HIGH_MIRROR[sfrOff]) begin
        strb.hitSfr  = 1'b1;            // upper banks mirror lower (R8)
        strb.hitZero = 1'b0;
        strb.sfrBank = {1'b0, bank[0]};
      end
    end else if ((bank[0] ? B1_SFR_MAP[sfrOff] : B0_SFR_MAP[sfrOff])) begin
      strb.hitSfr  = 1'b1;              // R9
      strb.hitZero = 1'b0;
      strb.sfrBank = {1'b0, bank[0]};
    end
  end

endmodule

// File: rtl/bankmap_dp.sv
module bankmap_dp
  import bankmap_pkg::*;
#(
  parameter int OFF_W       = 7,
  parameter int BANK_W      = 2,
  parameter int PTR_W       = 8,
  parameter int IDX_W       = 8,
  parameter int COMMON_SIZE = 16,
  parameter int B2_GPR_TOP  = 'h50
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    reqValid,
  input  logic                    reqWrite,
  input  logic                    isIndirect,
  input  logic [BANK_W-1:0]       bankSel,
  input  logic [OFF_W-1:0]        opField,
  input  logic                    irpBit,
  input  logic [PTR_W-1:0]        ptrVal,
  input  mapStrobe_t              strb,
  output logic [BANK_W+OFF_W-1:0] effAddr,
  output logic                    rspValid,
  output logic                    ramSel,
  output logic [IDX_W-1:0]        ramIdx,
  output logic                    sfrSel,
  output logic [BANK_W+OFF_W-1:0] sfrAddr,
  output logic                    readZero,
  output logic                    wrEn
);
  localparam int ADDR_W      = BANK_W + OFF_W;
  localparam int SFR_SPAN    = 2 ** (OFF_W - 2);
  localparam int COMMON_LO   = 2 ** OFF_W - COMMON_SIZE;
  localparam int BANK_GPR    = COMMON_LO - SFR_SPAN;
  localparam int B1_BASE     = BANK_GPR;
  localparam int B2_BASE     = 2 * BANK_GPR;
  localparam int COMMON_BASE = B2_BASE + (B2_GPR_TOP - SFR_SPAN);

  logic             useptr;
  logic [OFF_W-1:0] off;
  logic [IDX_W-1:0] idxNext;
  logic [IDX_W-1:0] rgnBase;
  logic [IDX_W-1:0] rgnStart;

  // Offset 0 of a direct access redirects through the pointer (R3).
  assign useptr  = isIndirect || (opField == '0);
  assign effAddr = useptr ? {irpBit, ptrVal} : {bankSel, opField};
  assign off     = effAddr[OFF_W-1:0];

  always_comb begin
    unique case (strb.rgn)
      RGN_B0:     begin rgnBase = IDX_W'(0);           rgnStart = IDX_W'(SFR_SPAN);  end
      RGN_B1:     begin rgnBase = IDX_W'(B1_BASE);     rgnStart = IDX_W'(SFR_SPAN);  end
      RGN_B2:     begin rgnBase = IDX_W'(B2_BASE);     rgnStart = IDX_W'(SFR_SPAN);  end
      default:    begin rgnBase = IDX_W'(COMMON_BASE); rgnStart = IDX_W'(COMMON_LO); end
    endcase
    idxNext = rgnBase + (IDX_W'(off) - rgnStart);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      ramSel   <= 1'b0;
      ramIdx   <= '0;
      sfrSel   <= 1'b0;
      sfrAddr  <= '0;
      readZero <= 1'b0;
      wrEn     <= 1'b0;
    end else begin
      rspValid <= reqValid;
      ramSel   <= reqValid && strb.hitRam;
      ramIdx   <= (reqValid && strb.hitRam) ? idxNext : '0;
      sfrSel   <= reqValid && strb.hitSfr;
      sfrAddr  <= (reqValid && strb.hitSfr) ? {strb.sfrBank, off} : '0;
      readZero <= reqValid && strb.hitZero;
      wrEn     <= reqValid && reqWrite && !strb.hitZero;
    end
  end

  a_r11_one_target: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> ($countones({ramSel, sfrSel, readZero}) == 1));

  a_r11_idle: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> (!rspValid && !ramSel && !sfrSel && !readZero && !wrEn));

  a_r10_hole_no_write: assert property (@(posedge clk) disable iff (!rstN)
    readZero |-> !wrEn);

  a_r4_self_pointer: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && isIndirect && ptrVal[OFF_W-1:0] == '0) |=> readZero);

  a_r5_common_fold: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !isIndirect && int'(opField) >= COMMON_LO) |=>
      (ramSel && ramIdx == IDX_W'(COMMON_BASE) + (IDX_W'($past(opField)) - IDX_W'(COMMON_LO))));

  a_r7_core_status: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !isIndirect && opField == OFF_W'(3)) |=>
      (sfrSel && sfrAddr == ADDR_W'(3)));

endmodule

// File: rtl/bankmap_top.sv
module bankmap_top
  import bankmap_pkg::*;
#(
  parameter int OFF_W  = 7,
  parameter int BANK_W = 2,
  parameter int PTR_W  = 8,
  parameter int IDX_W  = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    reqValid,
  input  logic                    reqWrite,
  input  logic                    isIndirect,
  input  logic [BANK_W-1:0]       bankSel,
  input  logic [OFF_W-1:0]        opField,
  input  logic                    irpBit,
  input  logic [PTR_W-1:0]        ptrVal,
  output logic                    rspValid,
  output logic                    ramSel,
  output logic [IDX_W-1:0]        ramIdx,
  output logic                    sfrSel,
  output logic [BANK_W+OFF_W-1:0] sfrAddr,
  output logic                    readZero,
  output logic                    wrEn
);
  logic [BANK_W+OFF_W-1:0] effAddr;
  mapStrobe_t              strb;

  bankmap_ctrl #(.OFF_W(OFF_W), .BANK_W(BANK_W)) u_ctrl (
    .effAddr (effAddr),
    .strb    (strb)
  );

  bankmap_dp #(.OFF_W(OFF_W), .BANK_W(BANK_W), .PTR_W(PTR_W), .IDX_W(IDX_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .reqWrite   (reqWrite),
    .isIndirect (isIndirect),
    .bankSel    (bankSel),
    .opField    (opField),
    .irpBit     (irpBit),
    .ptrVal     (ptrVal),
    .strb       (strb),
    .effAddr    (effAddr),
    .rspValid   (rspValid),
    .ramSel     (ramSel),
    .ramIdx     (ramIdx),
    .sfrSel     (sfrSel),
    .sfrAddr    (sfrAddr),
    .readZero   (readZero),
    .wrEn       (wrEn)
  );

endmodule

// File: tb/bankmap_top_test.sv
module bankmap_top_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       reqValid = 1'b0, reqWrite = 1'b0, isIndirect = 1'b0;
  logic [1:0] bankSel = '0;
  logic [6:0] opField = '0;
  logic       irpBit = 1'b0;
  logic [7:0] ptrVal = '0;
  logic       rspValid, ramSel, sfrSel, readZero, wrEn;
  logic [7:0] ramIdx;
  logic [8:0] sfrAddr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  bankmap_top uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .isIndirect(isIndirect), .bankSel(bankSel), .opField(opField),
    .irpBit(irpBit), .ptrVal(ptrVal), .rspValid(rspValid), .ramSel(ramSel),
    .ramIdx(ramIdx), .sfrSel(sfrSel), .sfrAddr(sfrAddr),
    .readZero(readZero), .wrEn(wrEn)
  );

  // kind: 0 = read as zero, 1 = RAM, 2 = special register
  typedef struct packed {
    logic       ind;
    logic [1:0] bank;
    logic [6:0] op;
    logic       irp;
    logic [7:0] ptr;
    logic       wr;
    logic [1:0] kind;
    logic [7:0] idx;
    logic [8:0] sfr;
  } vec_t;

  localparam int NVEC = 14;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 2'd0, 7'h25, 1'b0, 8'h00, 1'b1, 2'd1, 8'd5,   9'h000}, // R1 R6 bank 0
    '{1'b0, 2'd1, 7'h25, 1'b0, 8'h00, 1'b0, 2'd1, 8'd85,  9'h000}, // R1 R6 bank 1
    '{1'b0, 2'd2, 7'h25, 1'b0, 8'h00, 1'b1, 2'd1, 8'd165, 9'h000}, // R1 R6 bank 2
    '{1'b0, 2'd3, 7'h25, 1'b0, 8'h00, 1'b1, 2'd0, 8'd0,   9'h000}, // R6 R10 bank 3 hole
    '{1'b0, 2'd3, 7'h7A, 1'b0, 8'h00, 1'b1, 2'd1, 8'd218, 9'h000}, // R5 common
    '{1'b0, 2'd2, 7'h03, 1'b0, 8'h00, 1'b0, 2'd2, 8'd0,   9'h003}, // R7 core fold
    '{1'b0, 2'd3, 7'h06, 1'b0, 8'h00, 1'b1, 2'd2, 8'd0,   9'h086}, // R8 upper mirror
    '{1'b0, 2'd1, 7'h01, 1'b0, 8'h00, 1'b0, 2'd2, 8'd0,   9'h081}, // R9 bank 1 own
    '{1'b0, 2'd0, 7'h00, 1'b1, 8'h4F, 1'b1, 2'd1, 8'd207, 9'h000}, // R3 redirect
    '{1'b1, 2'd0, 7'h11, 1'b1, 8'h80, 1'b1, 2'd0, 8'd0,   9'h000}, // R4 self pointer
    '{1'b1, 2'd3, 7'h40, 1'b0, 8'hEF, 1'b0, 2'd1, 8'd159, 9'h000}, // R2 indirect
    '{1'b0, 2'd0, 7'h07, 1'b0, 8'h00, 1'b1, 2'd0, 8'd0,   9'h000}, // R9 R10 bank 0 hole
    '{1'b0, 2'd1, 7'h1E, 1'b0, 8'h00, 1'b0, 2'd0, 8'd0,   9'h000}, // R9 bank 1 hole
    '{1'b0, 2'd2, 7'h05, 1'b0, 8'h00, 1'b1, 2'd0, 8'd0,   9'h000}  // R8 R10 bank 2 hole
  };

  // Reference model written from the requirement text.
  function automatic logic [18:0] refMap(input logic [8:0] a);
    logic [6:0] off;
    logic [1:0] bk;
    logic [1:0] kind;
    logic [7:0] idx;
    logic [8:0] sfr;
    off = a[6:0]; bk = a[8:7]; kind = 2'd0; idx = 8'd0; sfr = 9'd0;
    if (off == 7'h00) kind = 2'd0;
    else if (off >= 7'h70) begin kind = 2'd1; idx = 8'd208 + 8'(off - 7'h70); end
    else if (off >= 7'h20) begin
      case (bk)
        2'd0: begin kind = 2'd1; idx = 8'(off - 7'h20); end
        2'd1: begin kind = 2'd1; idx = 8'd80 + 8'(off - 7'h20); end
        2'd2: if (off < 7'h50) begin kind = 2'd1; idx = 8'd160 + 8'(off - 7'h20); end
        default: ;
      endcase
    end else if (off inside {7'h02, 7'h03, 7'h04, 7'h0A, 7'h0B}) begin
      kind = 2'd2; sfr = {2'b00, off};
    end else begin
      case (bk)
        2'd0: if (off inside {7'h01, 7'h05, 7'h06, 7'h0C, [7'h0E:7'h12], [7'h15:7'h1A], 7'h1F}) begin
                kind = 2'd2; sfr = a; end
        2'd1: if (off inside {7'h01, 7'h05, 7'h06, 7'h0C, 7'h0E, 7'h12, [7'h18:7'h1D], 7'h1F}) begin
                kind = 2'd2; sfr = a; end
        default: if (off == 7'h01 || off == 7'h06) begin kind = 2'd2; sfr = {bk - 2'd2, off}; end
      endcase
    end
    return {kind, idx, sfr};
  endfunction

  task automatic checkOut(input string tag, input logic [1:0] kind,
                          input logic [7:0] idx, input logic [8:0] sfr, input logic wr);
    logic [13:0] got, exp;
    got = {rspValid, ramSel, sfrSel, readZero, ramIdx, wrEn, 1'b0};
    exp = {1'b1, kind == 2'd1, kind == 2'd2, kind == 2'd0,
           (kind == 2'd1) ? idx : 8'd0, wr && kind != 2'd0, 1'b0};
    checks++;
    if (got !== exp || sfrAddr !== ((kind == 2'd2) ? sfr : 9'd0)) begin
      errors++;
      $display("FAIL %s: got v/ram/sfr/zero/idx/wr=%h sfr=%h expected %h sfr=%h",
               tag, got, sfrAddr, exp, (kind == 2'd2) ? sfr : 9'd0);
    end
  endtask

  // Drive on the falling edge, result registered at the next rising edge.
  task automatic access(input logic ind, input logic [1:0] bk, input logic [6:0] op,
                        input logic irp, input logic [7:0] ptr, input logic wr);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; isIndirect = ind;
    bankSel = bk; opField = op; irpBit = irp; ptrVal = ptr;
    @(posedge clk);
    #1;
  endtask

  task automatic accessRef(input string tag, input logic ind, input logic [1:0] bk,
                           input logic [6:0] op, input logic irp, input logic [7:0] ptr,
                           input logic wr);
    logic [8:0]  eff;
    logic [18:0] r;
    eff = (ind || op == 7'h00) ? {irp, ptr} : {bk, op};
    r = refMap(eff);
    access(ind, bk, op, irp, ptr, wr);
    checkOut(tag, r[18:17], r[16:9], r[8:0], wr);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog R11: got hung run expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R11: reset state
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if ({rspValid, ramSel, sfrSel, readZero, wrEn, ramIdx, sfrAddr} !== '0) begin
      errors++;
      $display("FAIL R11 reset: got %b expected all zero",
               {rspValid, ramSel, sfrSel, readZero, wrEn, ramIdx, sfrAddr});
    end
    @(negedge clk); rstN = 1'b1;

    // Table of vectors
    for (int i = 0; i < NVEC; i++) begin
      access(VECS[i].ind, VECS[i].bank, VECS[i].op, VECS[i].irp, VECS[i].ptr, VECS[i].wr);
      checkOut($sformatf("table vector %0d", i), VECS[i].kind, VECS[i].idx, VECS[i].sfr, VECS[i].wr);
    end

    // R11: idle cycle gives no result
    @(negedge clk); reqValid = 1'b0; reqWrite = 1'b1; opField = 7'h30;
    @(posedge clk); #1;
    checks++;
    if ({rspValid, ramSel, sfrSel, readZero, wrEn} !== '0) begin
      errors++;
      $display("FAIL R11 idle: got %b expected 00000", {rspValid, ramSel, sfrSel, readZero, wrEn});
    end

    // R2: indirect ignores bankSel/opField
    accessRef("R2 indirect ignores direct fields", 1'b1, 2'd3, 7'h05, 1'b0, 8'h21, 1'b1);
    // R4: direct redirect whose pointer is itself offset 0 of bank 1
    accessRef("R4 redirect to self", 1'b0, 2'd2, 7'h00, 1'b0, 8'h80, 1'b1);
    // R10: write to bank 2 hole dropped
    accessRef("R10 bank 2 hole write", 1'b0, 2'd2, 7'h60, 1'b0, 8'h00, 1'b1);
    // R5: common from four banks, same index
    for (int b = 0; b < 4; b++)
      accessRef("R5 common per bank", 1'b0, 2'(b), 7'h7F, 1'b0, 8'h00, 1'b0);

    // Full sweep of direct addresses (R1 R3 R5 R6 R7 R8 R9 R10)
    for (int a = 0; a < 512; a++)
      accessRef("sweep direct R1/R6/R9", 1'b0, 2'(a >> 7), 7'(a), 1'b1, 8'h2A, 1'(a));
    // Full sweep of pointer addresses (R2 R4)
    for (int a = 0; a < 512; a++)
      accessRef("sweep indirect R2/R4", 1'b1, 2'd3, 7'h55, 1'(a >> 8), 8'(a), 1'(a >> 1));

    @(negedge clk); reqValid = 1'b0;
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule